// File: doc/BRIEF.md
# Memory-Resident Register Context Controller

This block holds a processor's register file in ordinary word-addressed RAM instead of flip-flops. The file is split into 32 contexts of 32 sixteen-bit registers each, occupying the top 1024 words (0xFFFC00 to 0xFFFFFF) of a 24-bit word address space. A register access from the datapath on bank `b`, index `i` becomes a RAM cycle at address 0xFFFC00 + b*32 + i. Index 0 is a hardwired zero. Four slots are kept live inside the block instead of in RAM: the flag word (index 22), the stack pointer (index 23) and the two halves of the 24-bit program counter (index 30 holds the low 16 bits, index 31 the upper 8 bits in its low byte).

A context switch copies the live flag, stack pointer and program counter into the outgoing bank's RAM slots, then fetches the same four slots of the incoming bank. Switches come from seven interrupt lines (level n enters bank n), from a software strobe naming a target bank, or from a return strobe that goes back to the bank that was running when the interrupt was taken. While a bank from 1 to 7 is current, further interrupts and software switches are held off. The block also forms the physical stack address of the current context: each context owns 1024 words of a 32-kword area that starts at 0xFF7C00.

Both data interfaces are request/acknowledge. On the register port the datapath raises `rf_req` with index, direction and write data, and holds them unchanged until a cycle where `rf_ack` is high; that cycle completes the transfer and read data is valid then. On the RAM port the block raises `mem_req` and holds address, direction and write data until `mem_ack`; the RAM may stall for any number of cycles and must present read data in the acknowledge cycle. Switch strobes are single-cycle control pulses, and interrupt lines are levels sampled only while the block is idle.

Top module: `regctx_top`

## Requirements
- R1: A register access on an index other than 0, 22, 23, 30 or 31 raises `mem_req` at address 0xFFFC00 + cur_bank*32 + index, in the direction of `rf_we`, with `rf_wdata` as write data. `rf_ack` follows `mem_ack` in the same cycle, and read data is `mem_rdata`.
- R2: Index 0 reads as zero. Writes to it are discarded. It is acknowledged in the request cycle and never raises `mem_req`.
- R3: Index 22 is the flag word, 23 the stack pointer, 30 the program counter bits 15:0, and 31 the program counter bits 23:16 (read back as zero-extended, written from `rf_wdata[7:0]`). These are acknowledged in the request cycle without `mem_req`. A write is visible from the next cycle, and `pc` and `sp` show the live values.
- R4: After reset the current bank is 0, flag, stack pointer and program counter are 0, `busy` is low and no RAM cycle is issued.
- R5: A switch first writes flag, stack pointer, PC low and PC high (in that order) to slots 22, 23, 30 and 31 of the outgoing bank. It then reads the same four slots of the incoming bank in the same order, one word per acknowledged RAM cycle. `cur_bank` takes the new value at the edge of the last read, and the live registers hold the loaded words.
- R6: `busy` rises in the cycle after an accepted switch request and stays high until the eighth RAM acknowledge. While it is high, RAM address and direction stay stable until acknowledged, and register requests are not acknowledged.
- R7: When the current bank is not 1 to 7 and any interrupt line is high, the block switches to the bank equal to the highest active level (line k is level k+1) and remembers the outgoing bank.
- R8: While the current bank is 1 to 7, interrupt lines are ignored.
- R9: A return strobe while the current bank is 1 to 7 switches back to the remembered bank. A return strobe in any other bank is ignored.
- R10: A software strobe switches to `sw_bank` only when the current bank is not 1 to 7 and the target is not 1 to 7. An interrupt in the same cycle takes precedence, and strobes during `busy` are ignored.
- R11: `stk_addr` equals 0xFF7C00 + cur_bank*1024 + sp[9:0]. The upper stack pointer bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_req | input | 1 | Register access request (valid) |
| rf_we | input | 1 | Register access is a write |
| rf_idx | input | 5 | Register index |
| rf_wdata | input | 16 | Register write data |
| rf_ack | output | 1 | Register access completes this cycle (ready) |
| rf_rdata | output | 16 | Register read data, valid with rf_ack |
| irq_req | input | 7 | Interrupt levels 1 to 7 (bit k is level k+1) |
| sw_req | input | 1 | Software switch strobe |
| sw_bank | input | 5 | Software switch target bank |
| reti_req | input | 1 | Return-from-interrupt strobe |
| mem_req | output | 1 | RAM cycle request (valid) |
| mem_we | output | 1 | RAM cycle is a write |
| mem_addr | output | 24 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_ack | input | 1 | RAM cycle completes this cycle (ready) |
| mem_rdata | input | 16 | RAM read data, valid with mem_ack |
| busy | output | 1 | Context switch in progress |
| cur_bank | output | 5 | Current register bank |
| pc | output | 24 | Live program counter |
| sp | output | 16 | Live stack pointer |
| stk_addr | output | 24 | Physical stack address of the current context |

## Verification
The zero register and the four live slots answer in the same cycle as the request. RAM-backed registers answer in whatever cycle the RAM acknowledges, so the bench samples `rf_ack`, `mem_req` and read data a fraction of a period after each falling edge, and keeps the request held until it sees the acknowledge. A live-slot write is checked by a read on a later access. A switch strobe is judged by `busy` one edge later. The eight RAM cycles of the switch are compared against a precomputed address, direction and data list as each one is acknowledged, and `cur_bank`, `pc` and `stk_addr` are checked only after `busy` falls, against values predicted by bench functions.

// File: rtl/regctx_pkg.sv
package regctx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_LOAD = 2'd2
  } ctx_state_e;

  // Live-slot register numbers; the save/load order follows the step count.
  localparam int unsigned SLOT_FLAG = 22;
  localparam int unsigned SLOT_STK  = 23;
  localparam int unsigned SLOT_PCL  = 30;
  localparam int unsigned SLOT_PCH  = 31;

  function automatic int unsigned slot_of(input logic [1:0] step);
    case (step)
      2'd0:    return SLOT_FLAG;
      2'd1:    return SLOT_STK;
      2'd2:    return SLOT_PCL;
      default: return SLOT_PCH;
    endcase
  endfunction

endpackage

// File: rtl/regctx_evsel.sv
module regctx_evsel #(
  parameter int BANK_W = 5,
  parameter int IRQ_N  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic [BANK_W-1:0] prev_bank,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic              sw_req,
  input  logic [BANK_W-1:0] sw_bank,
  input  logic              reti_req,
  output logic              go,
  output logic              go_irq,
  output logic [BANK_W-1:0] go_bank
);

  logic              in_irq;
  logic              sw_tgt_irq;
  logic [BANK_W-1:0] lvl;

  assign in_irq     = (cur_bank != '0) && (cur_bank <= BANK_W'(IRQ_N));
  assign sw_tgt_irq = (sw_bank != '0) && (sw_bank <= BANK_W'(IRQ_N));

  // Highest-numbered active line wins.
  always_comb begin
    lvl = '0;
    for (int i = 0; i < IRQ_N; i++) begin
      if (irq_req[i]) lvl = BANK_W'(i + 1);
    end
  end

  always_comb begin
    go      = 1'b0;
    go_irq  = 1'b0;
    go_bank = cur_bank;
    if (idle) begin
      if (!in_irq && (irq_req != '0)) begin
        go      = 1'b1;
        go_irq  = 1'b1;
        go_bank = lvl;
      end else if (in_irq && reti_req) begin
        go      = 1'b1;
        go_bank = prev_bank;
      end else if (!in_irq && sw_req && !sw_tgt_irq) begin
        go      = 1'b1;
        go_bank = sw_bank;
      end
    end
  end

  AST_IRQ_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    go && go_irq |-> (go_bank != '0) && (go_bank <= BANK_W'(IRQ_N))); // R7
  AST_IRQ_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    go && go_irq |-> ((irq_req >> go_bank) == '0)); // R7
  AST_IRQ_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cur_bank != '0) && (cur_bank <= BANK_W'(IRQ_N)) |-> !go_irq && (go_bank == prev_bank)); // R8
  AST_SW_NO_IRQ_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    go && !go_irq && !reti_req |-> !((go_bank != '0) && (go_bank <= BANK_W'(IRQ_N)))); // R10

endmodule

// File: rtl/regctx_core.sv
module regctx_core
  import regctx_pkg::*;
#(
  parameter int              BANK_W   = 5,
  parameter int              IDX_W    = 5,
  parameter int              DW       = 16,
  parameter int              AW       = 24,
  parameter logic [AW-1:0]   CTX_BASE = 24'hFFFC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_irq,
  input  logic [BANK_W-1:0] go_bank,
  input  logic              rf_req,
  input  logic              rf_we,
  input  logic [IDX_W-1:0]  rf_idx,
  input  logic [DW-1:0]     rf_wdata,
  output logic              rf_ack,
  output logic [DW-1:0]     rf_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              idle,
  output logic [BANK_W-1:0] cur_bank,
  output logic [BANK_W-1:0] prev_bank,
  output logic [DW-1:0]     sp,
  output logic [AW-1:0]     pc
);

  localparam int PCH_W = AW - DW;
  localparam logic [IDX_W-1:0] I_FLAG = IDX_W'(SLOT_FLAG);
  localparam logic [IDX_W-1:0] I_STK  = IDX_W'(SLOT_STK);
  localparam logic [IDX_W-1:0] I_PCL  = IDX_W'(SLOT_PCL);
  localparam logic [IDX_W-1:0] I_PCH  = IDX_W'(SLOT_PCH);

  ctx_state_e        st_q;
  logic [1:0]        step_q;
  logic [BANK_W-1:0] cur_q, tgt_q, prev_q;
  logic [DW-1:0]     flag_q, sp_q;
  logic [AW-1:0]     pc_q;

  logic              rf_live, is_zero, is_live;
  logic [IDX_W-1:0]  slot, acc_idx;
  logic [BANK_W-1:0] acc_bank;
  logic [DW-1:0]     save_word, live_rd;

  assign idle      = (st_q == ST_IDLE);
  assign busy      = !idle;
  assign cur_bank  = cur_q;
  assign prev_bank = prev_q;
  assign sp        = sp_q;
  assign pc        = pc_q;

  assign slot     = IDX_W'(slot_of(step_q));
  assign acc_bank = (st_q == ST_LOAD) ? tgt_q : cur_q;
  assign acc_idx  = idle ? rf_idx : slot;
  assign mem_addr = CTX_BASE + AW'({acc_bank, acc_idx});

  assign rf_live  = idle && !go && rf_req;
  assign is_zero  = (rf_idx == '0);
  assign is_live  = (rf_idx == I_FLAG) || (rf_idx == I_STK) ||
                    (rf_idx == I_PCL)  || (rf_idx == I_PCH);

  always_comb begin
    case (step_q)
      2'd0:    save_word = flag_q;
      2'd1:    save_word = sp_q;
      2'd2:    save_word = pc_q[DW-1:0];
      default: save_word = {{(DW-PCH_W){1'b0}}, pc_q[AW-1:DW]};
    endcase
  end

  always_comb begin
    if (rf_idx == I_FLAG)     live_rd = flag_q;
    else if (rf_idx == I_STK) live_rd = sp_q;
    else if (rf_idx == I_PCL) live_rd = pc_q[DW-1:0];
    else                      live_rd = {{(DW-PCH_W){1'b0}}, pc_q[AW-1:DW]};
  end

  assign mem_req   = busy || (rf_live && !is_zero && !is_live);
  assign mem_we    = (st_q == ST_SAVE) || (idle && rf_we);
  assign mem_wdata = (st_q == ST_SAVE) ? save_word : rf_wdata;
  assign rf_ack    = rf_live && ((is_zero || is_live) ? 1'b1 : mem_ack);
  assign rf_rdata  = is_zero ? '0 : (is_live ? live_rd : mem_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      cur_q  <= '0;
      tgt_q  <= '0;
      prev_q <= '0;
      flag_q <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            tgt_q  <= go_bank;
            step_q <= '0;
            st_q   <= ST_SAVE;
            if (go_irq) prev_q <= cur_q;
          end else if (rf_live && rf_we && is_live) begin
            if (rf_idx == I_FLAG)     flag_q <= rf_wdata;
            else if (rf_idx == I_STK) sp_q <= rf_wdata;
            else if (rf_idx == I_PCL) pc_q[DW-1:0] <= rf_wdata;
            else                      pc_q[AW-1:DW] <= rf_wdata[PCH_W-1:0];
          end
        end
        ST_SAVE: begin
          if (mem_ack) begin
            step_q <= step_q + 2'd1;
            if (step_q == 2'd3) st_q <= ST_LOAD;
          end
        end
        default: begin
          if (mem_ack) begin
            case (step_q)
              2'd0:    flag_q <= mem_rdata;
              2'd1:    sp_q <= mem_rdata;
              2'd2:    pc_q[DW-1:0] <= mem_rdata;
              default: pc_q[AW-1:DW] <= mem_rdata[PCH_W-1:0];
            endcase
            step_q <= step_q + 2'd1;
            if (step_q == 2'd3) begin
              cur_q <= tgt_q;
              st_q  <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  AST_CTX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr >= CTX_BASE); // R1
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rf_req && (rf_idx == '0) |-> !mem_req && (rf_rdata == '0)); // R2
  AST_SWITCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rf_ack); // R6
  AST_SAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_we); // R5
  AST_BANK_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> $past(st_q == ST_LOAD && mem_ack)); // R5

endmodule

// File: rtl/regctx_stkaddr.sv
module regctx_stkaddr #(
  parameter int            BANK_W    = 5,
  parameter int            AW        = 24,
  parameter int            STK_WORDS = 1024,
  parameter logic [AW-1:0] STK_BASE  = 24'hFF7C00
) (
  input  logic [BANK_W-1:0]            bank,
  input  logic [$clog2(STK_WORDS)-1:0] sp_off,
  output logic [AW-1:0]                stk_addr
);

  assign stk_addr = STK_BASE + AW'({bank, sp_off});

endmodule

// File: rtl/regctx_top.sv
module regctx_top #(
  parameter int            BANK_W    = 5,
  parameter int            IDX_W     = 5,
  parameter int            DW        = 16,
  parameter int            AW        = 24,
  parameter int            IRQ_N     = 7,
  parameter int            STK_WORDS = 1024,
  parameter logic [AW-1:0] CTX_BASE  = 24'hFFFC00,
  parameter logic [AW-1:0] STK_BASE  = 24'hFF7C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_req,
  input  logic              rf_we,
  input  logic [IDX_W-1:0]  rf_idx,
  input  logic [DW-1:0]     rf_wdata,
  output logic              rf_ack,
  output logic [DW-1:0]     rf_rdata,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic              sw_req,
  input  logic [BANK_W-1:0] sw_bank,
  input  logic              reti_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic [BANK_W-1:0] cur_bank,
  output logic [AW-1:0]     pc,
  output logic [DW-1:0]     sp,
  output logic [AW-1:0]     stk_addr
);

  localparam int SP_OFF_W = $clog2(STK_WORDS);

  logic              idle, go, go_irq;
  logic [BANK_W-1:0] go_bank, prev_bank;

  regctx_evsel #(.BANK_W(BANK_W), .IRQ_N(IRQ_N)) evsel_i (
    .clk(clk), .rst_n(rst_n), .idle(idle), .cur_bank(cur_bank),
    .prev_bank(prev_bank), .irq_req(irq_req), .sw_req(sw_req),
    .sw_bank(sw_bank), .reti_req(reti_req), .go(go), .go_irq(go_irq),
    .go_bank(go_bank)
  );

  regctx_core #(.BANK_W(BANK_W), .IDX_W(IDX_W), .DW(DW), .AW(AW),
                .CTX_BASE(CTX_BASE)) core_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_irq(go_irq), .go_bank(go_bank),
    .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .rf_ack(rf_ack), .rf_rdata(rf_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .idle(idle), .cur_bank(cur_bank),
    .prev_bank(prev_bank), .sp(sp), .pc(pc)
  );

  regctx_stkaddr #(.BANK_W(BANK_W), .AW(AW), .STK_WORDS(STK_WORDS),
                   .STK_BASE(STK_BASE)) stk_i (
    .bank(cur_bank), .sp_off(sp[SP_OFF_W-1:0]), .stk_addr(stk_addr)
  );

endmodule

// File: tb/regctx_top_tb_top.sv
`timescale 1ns/1ps
module regctx_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_req = 1'b0, rf_we = 1'b0;
  logic [4:0]  rf_idx = '0;
  logic [15:0] rf_wdata = '0;
  logic        rf_ack;
  logic [15:0] rf_rdata;
  logic [6:0]  irq_req = '0;
  logic        sw_req = 1'b0, reti_req = 1'b0;
  logic [4:0]  sw_bank = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic        busy;
  logic [4:0]  cur_bank;
  logic [23:0] pc, stk_addr;
  logic [15:0] sp;

  always #4 clk = ~clk;

  regctx_top dut_i (
    .clk(clk), .rst_n(rst_n), .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .rf_ack(rf_ack), .rf_rdata(rf_rdata),
    .irq_req(irq_req), .sw_req(sw_req), .sw_bank(sw_bank), .reti_req(reti_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .cur_bank(cur_bank), .pc(pc), .sp(sp), .stk_addr(stk_addr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] bmem [0:1023];

  // bench model of the block's visible state
  logic [4:0]  m_bank = '0, m_prev = '0;
  logic [15:0] m_flag = '0, m_sp = '0;
  logic [23:0] m_pc = '0;

  // expected RAM cycles of the switch in progress
  logic [23:0] sq_addr [0:7];
  logic        sq_we   [0:7];
  logic [15:0] sq_wd   [0:7];
  int          sq_k = 0;

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] slot_n(input int s);
    case (s)
      0: return 5'd22;
      1: return 5'd23;
      2: return 5'd30;
      default: return 5'd31;
    endcase
  endfunction

  function automatic bit is_live(input logic [4:0] i);
    return (i == 5'd22) || (i == 5'd23) || (i == 5'd30) || (i == 5'd31);
  endfunction

  function automatic logic [15:0] live_val(input logic [4:0] i);
    case (i)
      5'd22: return m_flag;
      5'd23: return m_sp;
      5'd30: return m_pc[15:0];
      default: return {8'h00, m_pc[23:16]};
    endcase
  endfunction

  function automatic bit irq_bank(input logic [4:0] b);
    return (b >= 5'd1) && (b <= 5'd7);
  endfunction

  function automatic logic [23:0] ctx_addr(input logic [4:0] b, input logic [4:0] i);
    return 24'hFFFC00 + {14'd0, b, i};
  endfunction

  function automatic logic [23:0] stk_exp(input logic [4:0] b, input logic [15:0] s);
    return 24'hFF7C00 + {9'd0, b, s[9:0]};
  endfunction

  // RAM model: random wait states, data presented in the acknowledge cycle
  always @(negedge clk) begin
    #2;
    mem_ack = 1'b0;
    if (mem_req && ($urandom % 3 != 0)) begin
      mem_ack   = 1'b1;
      mem_rdata = bmem[mem_addr[9:0]];
      if (mem_addr < 24'hFFFC00) chk_eq("R1", "ram window", mem_addr, 24'hFFFC00);
      if (busy) begin
        if (sq_k < 8) begin
          chk_eq("R5", "switch addr", mem_addr, sq_addr[sq_k]);
          chk_eq("R5", "switch dir", mem_we, sq_we[sq_k]);
          if (sq_we[sq_k]) chk_eq("R5", "switch save data", mem_wdata, sq_wd[sq_k]);
        end
        sq_k++;
      end
      if (mem_we) bmem[mem_addr[9:0]] = mem_wdata;
    end
  end

  // R6: no register acknowledge while a switch runs
  always @(negedge clk) begin
    #3;
    if (rst_n && busy && rf_req) chk_eq("R6", "stall ack", rf_ack, 1'b0);
  end

  task automatic rf_op(input logic [4:0] idx, input bit we, input logic [15:0] wd);
    int  waits = 0;
    bit  got = 1'b0;
    rf_req = 1'b1; rf_we = we; rf_idx = idx; rf_wdata = wd;
    while (!got) begin
      #3;
      if (rf_ack) begin
        got = 1'b1;
        if (idx == 5'd0) begin
          chk_eq("R2", "zero no ram", mem_req, 1'b0);
          chk_eq("R2", "zero same cycle", waits, 0);
          if (!we) chk_eq("R2", "zero read", rf_rdata, 16'h0);
        end else if (is_live(idx)) begin
          chk_eq("R3", "live no ram", mem_req, 1'b0);
          chk_eq("R3", "live same cycle", waits, 0);
          if (!we) chk_eq("R3", "live read", rf_rdata, live_val(idx));
          else begin
            case (idx)
              5'd22: m_flag = wd;
              5'd23: m_sp = wd;
              5'd30: m_pc[15:0] = wd;
              default: m_pc[23:16] = wd[7:0];
            endcase
          end
        end else begin
          chk_eq("R1", "ram addr", mem_addr, ctx_addr(m_bank, idx));
          chk_eq("R1", "ram dir", mem_we, we);
          if (we) chk_eq("R1", "ram wdata", mem_wdata, wd);
          else    chk_eq("R1", "ram rdata", rf_rdata, bmem[{m_bank, idx}]);
        end
      end
      @(negedge clk);
      waits++;
    end
    rf_req = 1'b0;
    #3;
    chk_eq("R3", "pc port", pc, m_pc);
    chk_eq("R11", "stack addr", stk_addr, stk_exp(m_bank, m_sp));
    @(negedge clk);
  endtask

  task automatic predict(input logic [6:0] irq, input bit sw, input logic [4:0] swb,
                         input bit rt, output bit go, output bit by_irq,
                         output logic [4:0] tgt, output string tag);
    go = 1'b0; by_irq = 1'b0; tgt = m_bank; tag = "R10";
    if (irq_bank(m_bank)) begin
      if (irq != 0) tag = "R8";
      if (rt) begin go = 1'b1; tgt = m_prev; tag = "R9"; end
    end else if (irq != 0) begin
      go = 1'b1; by_irq = 1'b1; tag = "R7";
      for (int i = 0; i < 7; i++) if (irq[i]) tgt = 5'(i + 1);
    end else if (sw && !irq_bank(swb)) begin
      go = 1'b1; tgt = swb;
    end else if (rt) tag = "R9";
  endtask

  task automatic do_switch(input logic [6:0] irq, input bit sw, input logic [4:0] swb,
                           input bit rt);
    bit          go, by_irq;
    logic [4:0]  tgt, old;
    string       tag;
    logic [15:0] ld [0:3];
    logic [15:0] sv [0:3];
    int          guard = 0;
    predict(irq, sw, swb, rt, go, by_irq, tgt, tag);
    old = m_bank;
    sv[0] = m_flag; sv[1] = m_sp; sv[2] = m_pc[15:0]; sv[3] = {8'h00, m_pc[23:16]};
    for (int s = 0; s < 4; s++) begin
      ld[s] = (tgt == old) ? sv[s] : bmem[{tgt, slot_n(s)}];
      sq_addr[s] = ctx_addr(old, slot_n(s)); sq_we[s] = 1'b1; sq_wd[s] = sv[s];
      sq_addr[s+4] = ctx_addr(tgt, slot_n(s)); sq_we[s+4] = 1'b0; sq_wd[s+4] = '0;
    end
    sq_k = 0;
    irq_req = irq; sw_req = sw; sw_bank = swb; reti_req = rt;
    @(negedge clk);
    irq_req = '0; sw_req = 1'b0; reti_req = 1'b0;
    #3;
    chk_eq(go ? "R6" : tag, "busy after strobe", busy, go);
    if (go) begin
      while (busy && guard < 1000) begin
        @(negedge clk); #3; guard++;
      end
      chk_eq("R5", "ram cycles", sq_k, 8);
      chk_eq(tag, "new bank", cur_bank, tgt);
      if (by_irq) m_prev = old;
      m_bank = tgt;
      m_flag = ld[0]; m_sp = ld[1]; m_pc = {ld[3][7:0], ld[2]};
      chk_eq("R5", "loaded pc", pc, m_pc);
      chk_eq("R5", "loaded sp", sp, m_sp);
      for (int s = 0; s < 4; s++)
        if (tgt != old) chk_eq("R5", "saved slot", bmem[{old, slot_n(s)}], sv[s]);
    end else begin
      chk_eq(tag, "bank kept", cur_bank, old);
      chk_eq(tag, "no ram", mem_req, 1'b0);
    end
    chk_eq("R11", "stack addr", stk_addr, stk_exp(m_bank, m_sp));
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 1024; a++) bmem[a] = 16'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    // R4: reset state
    chk_eq("R4", "bank", cur_bank, 5'd0);
    chk_eq("R4", "pc", pc, 24'h0);
    chk_eq("R4", "sp", sp, 16'h0);
    chk_eq("R4", "busy", busy, 1'b0);
    chk_eq("R4", "mem_req", mem_req, 1'b0);
    @(negedge clk);
    rf_op(5'd22, 1'b0, '0);             // R4 flag reads zero

    // directed register accesses
    rf_op(5'd5, 1'b1, 16'h1234);        // R1
    rf_op(5'd5, 1'b0, '0);
    chk_eq("R1", "readback", bmem[{5'd0, 5'd5}], 16'h1234);
    rf_op(5'd0, 1'b1, 16'hFFFF);        // R2 write discarded
    rf_op(5'd0, 1'b0, '0);
    rf_op(5'd31, 1'b1, 16'hABCD);       // R3 upper pc byte
    rf_op(5'd31, 1'b0, '0);
    rf_op(5'd30, 1'b1, 16'h5678);
    rf_op(5'd23, 1'b1, 16'hFC05);       // R11 upper sp bits ignored
    rf_op(5'd22, 1'b1, 16'h00A5);

    for (int n = 0; n < 80; n++)
      rf_op(5'($urandom), 1'($urandom), 16'($urandom));

    // directed switches
    do_switch(7'd0, 1'b1, 5'd9, 1'b0);          // R10 software switch
    do_switch(7'd0, 1'b1, 5'd3, 1'b0);          // R10 target 1..7 refused
    do_switch(7'b0010010, 1'b0, 5'd0, 1'b0);    // R7 levels 2 and 5 -> 5
    do_switch(7'b1000000, 1'b0, 5'd0, 1'b0);    // R8 held off
    do_switch(7'd0, 1'b1, 5'd12, 1'b0);         // R10 locked out
    rf_op(5'd22, 1'b1, 16'h7E7E);
    do_switch(7'd0, 1'b0, 5'd0, 1'b1);          // R9 return to 9
    do_switch(7'd0, 1'b0, 5'd0, 1'b1);          // R9 ignored outside
    do_switch(7'b0000001, 1'b1, 5'd20, 1'b0);   // R10 irq wins over software
    rf_req = 1'b1; rf_we = 1'b0; rf_idx = 5'd22;
    do_switch(7'd0, 1'b0, 5'd0, 1'b1);          // R6 request held across switch
    rf_op(5'd22, 1'b0, '0);
    do_switch(7'd0, 1'b1, 5'd9, 1'b0);          // R5 same bank
    rf_op(5'd23, 1'b0, '0);

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      for (int k = 0; k < 3; k++)
        rf_op(5'($urandom), 1'($urandom), 16'($urandom));
      do_switch(($urandom % 4 == 0) ? 7'($urandom) : 7'd0, 1'($urandom),
                5'($urandom), ($urandom % 3 == 0));
    end

    done = 1'b1;
    finish_run();
  end

endmodule